// File: doc/BRIEF.md
# Timer Tick Reinjection Controller

This block sits between the expiry strobe of a periodic timer and an edge-sensitive interrupt line. A consumer that services interrupts slowly would otherwise lose timer ticks. The block keeps a saturating count of expiries that have not yet been delivered. It hands them out one at a time, and it waits for an acknowledge between two deliveries.

Each cycle, a service request asks the block to deliver. A delivery happens only when ticks are outstanding and the previous interrupt has been acknowledged. It appears as a single-cycle pulse on the interrupt output. Three inputs clear the backlog and re-arm delivery: a change of the interrupt mask to the unmasked state, a reprogram of the timer, and reset.

Top module: `tick_reinject`

## Requirements
- R1: After reset, the interrupt output is low, no ticks are outstanding and the acknowledge flag is set. A single expiry followed by a service request therefore produces an interrupt with no acknowledge in between.
- R2: A service request produces an interrupt only when the outstanding count is nonzero and the acknowledge flag is set. A service request with nothing outstanding produces no interrupt.
- R3: Delivering an interrupt clears the acknowledge flag. Further service requests produce no interrupt until an acknowledge arrives, even while ticks remain outstanding.
- R4: An acknowledge (`ack_i`=1) sets the acknowledge flag and lowers the outstanding count by one, saturating at zero. An acknowledge in the same cycle as a delivery leaves the flag set.
- R5: Each expiry (`expiry_i`=1) raises the outstanding count by one. The count saturates at 2^CNT_W-1 and never wraps.
- R6: When an expiry and an acknowledge arrive in the same cycle, the outstanding count is unchanged and the acknowledge flag ends up set.
- R7: An unmask event (`mask_chg_i`=1 with `mask_val_i`=0) clears the outstanding count and sets the acknowledge flag. A mask change with `mask_val_i`=1 has no effect.
- R8: A reprogram strobe (`reprog_i`=1) clears the outstanding count and sets the acknowledge flag. A clear takes priority over a same-cycle expiry, acknowledge or service request, and no interrupt is delivered in that cycle.
- R9: `irq_o` is registered. It is high in the cycle after the one where the delivery condition held, and it is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| expiry_i | input | 1 | Timer expiry strobe |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| mask_chg_i | input | 1 | Interrupt mask change strobe |
| mask_val_i | input | 1 | New mask value with the change strobe; 0 means unmasked |
| reprog_i | input | 1 | Timer reprogram strobe |
| service_i | input | 1 | Request to deliver an outstanding tick |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Several functions of this block can fall in the same cycle, and the bench drives those collisions on purpose. An expiry and an acknowledge arrive together, first with the flag set and then with it clear. An acknowledge lands in the same cycle as a delivery. A reprogram lands on top of an expiry or a service request. Each collision is judged afterwards by probing the interrupt output with service requests: whether an interrupt appears, and how many appear before the backlog drains, shows what happened to the hidden count and flag.

// File: rtl/tick_reinject_pkg.sv
package tick_reinject_pkg;

  // Saturating up/down step; simultaneous up and down cancel.
  function automatic logic [31:0] sat_step(input logic [31:0] cur,
                                           input logic [31:0] top,
                                           input logic        up,
                                           input logic        down);
    logic [31:0] nxt;
    nxt = cur;
    if (up && !down) begin
      if (cur != top) nxt = cur + 32'd1;
    end else if (down && !up) begin
      if (cur != 32'd0) nxt = cur - 32'd1;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/pend_counter.sv
module pend_counter #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic clr,
  output logic nonzero
);
  import tick_reinject_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = CNT_W'(sat_step(32'(cnt_q), 32'(CNT_MAX), inc, dec));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign nonzero = |cnt_q;

  // R8
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && inc && !dec && !clr) |=> (cnt_q == CNT_MAX));

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && dec && !inc && !clr) |=> (cnt_q == '0));

  // R6
  net_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/ack_gate.sv
module ack_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  input  logic clr,
  input  logic fire,
  output logic flag,
  output logic irq
);

  logic flag_q;
  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      if (clr || ack_i) flag_q <= 1'b1;
      else if (fire)    flag_q <= 1'b0;
      irq_q <= fire;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;

  // R4
  ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> flag_q);

  // R3
  fire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ack_i && !clr) |=> !flag_q);

  // R9
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

endmodule

// File: rtl/tick_reinject.sv
module tick_reinject #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expiry_i,
  input  logic ack_i,
  input  logic mask_chg_i,
  input  logic mask_val_i,
  input  logic reprog_i,
  input  logic service_i,
  output logic irq_o
);

  logic clr;
  logic pending;
  logic flag;
  logic fire;

  // Unmask and reprogram both flush the backlog.
  assign clr  = reprog_i || (mask_chg_i && !mask_val_i);
  assign fire = service_i && pending && flag && !clr && !irq_o;

  pend_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (expiry_i),
    .dec     (ack_i),
    .clr     (clr),
    .nonzero (pending)
  );

  ack_gate u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .ack_i (ack_i),
    .clr   (clr),
    .fire  (fire),
    .flag  (flag),
    .irq   (irq_o)
  );

  // R2
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(service_i));

  // R8
  clr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !irq_o);

endmodule

// File: tb/test_tick_reinject.sv
module test_tick_reinject;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic expiry_i = 1'b0, ack_i = 1'b0, mask_chg_i = 1'b0, mask_val_i = 1'b0;
  logic reprog_i = 1'b0, service_i = 1'b0;
  logic irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  bit    q_exp[$];
  string q_tag[$];

  always #5 clk = ~clk;

  tick_reinject #(.CNT_W(4)) i_tick_reinject (
    .clk(clk), .rst_n(rst_n), .expiry_i(expiry_i), .ack_i(ack_i),
    .mask_chg_i(mask_chg_i), .mask_val_i(mask_val_i), .reprog_i(reprog_i),
    .service_i(service_i), .irq_o(irq_o)
  );

  // Monitor: after each edge, compare irq_o against the oldest expectation.
  always @(posedge clk) begin
    #2;
    if (rst_n && q_exp.size() > 0) begin
      bit    e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      total++;
      if (irq_o !== e) begin
        bad++;
        $display("FAIL %s: irq_o=%0b expected=%0b", t, irq_o, e);
      end
    end
  end

  // Driver: apply one cycle of inputs and queue the expected irq.
  task automatic step(input bit e, input bit a, input bit mc, input bit mv,
                      input bit rp, input bit sv, input bit exp, input string tag);
    expiry_i = e; ack_i = a; mask_chg_i = mc; mask_val_i = mv;
    reprog_i = rp; service_i = sv;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    @(negedge clk);
    expiry_i = 0; ack_i = 0; mask_chg_i = 0; mask_val_i = 0;
    reprog_i = 0; service_i = 0;
  endtask

  task automatic tick(input bit exp, input string tag); step(1,0,0,0,0,0,exp,tag); endtask
  task automatic ack (input bit exp, input string tag); step(0,1,0,0,0,0,exp,tag); endtask
  task automatic svc (input bit exp, input string tag); step(0,0,0,0,0,1,exp,tag); endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (irq_o !== 1'b0) begin
      bad++;
      $display("FAIL R1: irq_o=%0b expected=0 in reset", irq_o);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2: reset state and empty backlog
    step(0,0,0,0,0,0,0,"R1 idle after reset");
    svc(0, "R2 service with nothing pending");
    tick(0, "R1 first expiry");
    svc(1, "R1 flag set out of reset");
    step(0,0,0,0,0,0,0,"R9 pulse lasts one cycle");

    // R3: no second delivery without acknowledge (count now 2)
    tick(0, "R3 expiry");
    svc(0, "R3 blocked until acknowledge");

    // R4: acknowledge decrements and re-arms; saturates at zero
    ack(0, "R4 ack");
    svc(1, "R4 re-armed by ack");
    ack(0, "R4 ack to zero");
    svc(0, "R4 count reached zero");
    ack(0, "R4 ack at zero");
    tick(0, "R4 expiry after ack at zero");
    svc(1, "R4 one tick outstanding");
    ack(0, "R4 ack");
    svc(0, "R4 no underflow wrap");

    // R6: simultaneous expiry and acknowledge
    tick(0, "R6 setup expiry");
    step(1,1,0,0,0,0,0,"R6 collide with flag set");
    svc(1, "R6 count kept at one");
    step(1,1,0,0,0,0,0,"R6 collide with flag clear");
    svc(1, "R6 flag set by collision");
    ack(0, "R6 drain");
    svc(0, "R6 drained to zero");

    // R9 / R4: ack together with delivery, then held service
    tick(0, "R9 setup");
    tick(0, "R9 setup");
    step(0,1,0,0,0,1,1,"R4 deliver with ack same cycle");
    svc(0, "R9 no back-to-back pulse");
    svc(1, "R4 flag stayed set");
    ack(0, "R9 drain");
    svc(0, "R9 drained");

    // R5: saturation at 15
    for (int i = 0; i < 20; i++) tick(0, "R5 fill");
    for (int i = 0; i < 15; i++) begin
      svc(1, "R5 saturated backlog delivers");
      ack(0, "R5 ack");
    end
    svc(0, "R5 exactly fifteen held");

    // R7: mask change
    tick(0, "R7 setup");
    tick(0, "R7 setup");
    tick(0, "R7 setup");
    step(0,0,1,1,0,0,0,"R7 mask to masked");
    svc(1, "R7 masking had no effect");
    step(0,0,1,0,0,0,0,"R7 unmask");
    svc(0, "R7 backlog cleared");
    tick(0, "R7 expiry after unmask");
    svc(1, "R7 flag set by unmask");
    ack(0, "R7 drain");

    // R8: reprogram
    tick(0, "R8 setup");
    tick(0, "R8 setup");
    svc(1, "R8 deliver");
    step(1,0,0,0,1,0,0,"R8 reprogram with expiry");
    svc(0, "R8 clear beats expiry");
    tick(0, "R8 expiry");
    step(0,0,0,0,1,1,0,"R8 clear blocks service");
    svc(0, "R8 backlog cleared");
    tick(0, "R8 expiry");
    svc(1, "R8 flag set by reprogram");
    ack(0, "R8 drain");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule